// File: doc/BRIEF.md
# Home Directory Controller with Full Sharer Vector

This block is the home node of a directory-based coherence scheme for a multiprocessor whose private caches run MESI. For every memory block it owns, it keeps one of three directory states (no holder, shared, or single owner that may be clean or dirty) and a sharer vector with one bit per cache. Caches send it read and read-for-ownership requests. It answers with a data reply, a reply without data, or a refusal. Where other caches hold the block, it sends them invalidations or a downgrade intervention. It counts the invalidation acknowledgements that come back.

The controller serialises all accesses to a block. Each accepted request holds the controller for a fixed lookup time. A block stays marked busy from the moment its transaction is issued until the requester returns a final completion acknowledgement. Any request that reaches a busy block in that window is refused, and the requester retries later. Owner data forwarding, memory timing and the network are outside the block.

The FSM has these states: IDLE (ready for a request), LOOKUP (occupancy countdown), ISSUE (emit reply and/or forwarded message), WAIT_INV (count invalidation acknowledgements), GRANT (ownership reply after the last acknowledgement) and REFUSE (refusal to a busy block). Its transitions are:
- IDLE to LOOKUP on a request to a free block.
- IDLE to REFUSE on a request to a busy block.
- LOOKUP to ISSUE when the countdown ends.
- ISSUE to WAIT_INV when invalidations were sent.
- ISSUE to IDLE otherwise.
- WAIT_INV to GRANT on the last counted acknowledgement.
- GRANT to IDLE and REFUSE to IDLE unconditionally.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is in the no-holder state with an empty sharer vector, `req_ready` is 1, and neither `rsp_valid` nor `fwd_valid` is asserted.
- R2: A read (`req_excl`=0) to a block with no holder produces a data reply (`rsp_kind`=0) to the requester. The block becomes owned with only the requester's bit set.
- R3: A read to a shared block produces a data reply (`rsp_kind`=0) and adds the requester to the sharer vector.
- R4: A read to a block owned by another cache produces no reply. It produces one intervention (`fwd_intv`=1) whose `fwd_mask` has only the owner's bit set and whose `fwd_req` carries the requester ID. The block becomes shared with both owner and requester bits set.
- R5: A read-for-ownership (`req_excl`=1) to a block held by other caches sends one invalidation (`fwd_intv`=0) whose mask is the sharer vector without the requester's bit. No reply is sent until that many acknowledgements have arrived. After the reply, the requester is the only holder.
- R6: The ownership reply is a data reply (`rsp_kind`=0) when the requester held no copy of a shared block. It is a reply without data (`rsp_kind`=1) when the requester already held a copy, or when the previous owner supplies the data. When no other cache holds the block, this reply is issued directly from ISSUE with no invalidation.
- R7: A read-for-ownership to a block with no holder produces a data reply, and the requester becomes the owner.
- R8: A cache that evicted a shared block silently is still sent an invalidation and must acknowledge it. After that transaction its bit is clear.
- R9: A request to a block whose transaction has not yet received its final acknowledgement (`ack_fin`=1) is refused with `rsp_kind`=2 in the cycle after acceptance, and the directory entry is left unchanged. After the final acknowledgement, requests to the block are served.
- R10: The first outgoing message for an accepted, non-refused request appears exactly `OCC` clock cycles after the accepting edge. `req_ready` is low while a request is being processed.
- R11: An invalidation acknowledgement that names another block, or that comes from a cache that was not sent the invalidation, is not counted toward completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_excl | input | 1 | 0 = read, 1 = read-for-ownership |
| req_src | input | $clog2(NCACHE) | Requesting cache ID |
| req_blk | input | $clog2(NBLK) | Block index |
| ack_valid | input | 1 | Acknowledgement present |
| ack_fin | input | 1 | 1 = final completion ack from requester, 0 = invalidation ack |
| ack_src | input | $clog2(NCACHE) | Acknowledging cache ID |
| ack_blk | input | $clog2(NBLK) | Block the acknowledgement refers to |
| rsp_valid | output | 1 | Reply to requester present |
| rsp_kind | output | 2 | 0 data reply, 1 reply without data, 2 refusal |
| rsp_dst | output | $clog2(NCACHE) | Reply destination |
| rsp_blk | output | $clog2(NBLK) | Block of the reply |
| fwd_valid | output | 1 | Forwarded message present |
| fwd_intv | output | 1 | 1 intervention (downgrade), 0 invalidation |
| fwd_mask | output | NCACHE | Target caches, one bit each |
| fwd_req | output | $clog2(NCACHE) | Requester ID carried with the message |
| fwd_blk | output | $clog2(NBLK) | Block of the forwarded message |

## Verification
The block is driven through reads and read-for-ownership requests against each of the three directory states, so a wrong state decode shows up as the wrong message kind or the wrong target mask. A later request to the same block then reveals which sharer bits a previous transaction left behind. This is how silent-eviction cleanup and the sole-owner result of an invalidation round are checked. Acknowledgements are sent one at a time, with stray ones for other blocks and other caches mixed in, so early grants are separated from correct counting. A request made before the final completion acknowledgement, followed by a retry after it, separates refusal from deferral and shows that a refusal leaves the directory unchanged.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        DS_U  = 2'd0,
        DS_S  = 2'd1,
        DS_EM = 2'd2
    } dstate_e;

    typedef enum logic [1:0] {
        RK_DATA   = 2'd0,
        RK_NODATA = 2'd1,
        RK_NACK   = 2'd2
    } rkind_e;

    typedef enum logic [2:0] {
        F_IDLE     = 3'd0,
        F_LOOKUP   = 3'd1,
        F_ISSUE    = 3'd2,
        F_WAIT_INV = 3'd3,
        F_GRANT    = 3'd4,
        F_REFUSE   = 3'd5
    } fsm_e;

endpackage

// File: rtl/dir_table.sv
module dir_table
    import dir_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int NBLK   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NBLK)-1:0] rd_blk,
    output dstate_e                 rd_state,
    output logic [NCACHE-1:0]       rd_vec,
    input  logic                    wr_en,
    input  logic [$clog2(NBLK)-1:0] wr_blk,
    input  dstate_e                 wr_state,
    input  logic [NCACHE-1:0]       wr_vec
);
    localparam int BW = $clog2(NBLK);

    dstate_e           st_q  [NBLK];
    logic [NCACHE-1:0] vec_q [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= DS_U;
                vec_q[g] <= '0;
            end else if (wr_en && wr_blk == BW'(g)) begin
                st_q[g]  <= wr_state;
                vec_q[g] <= wr_vec;
            end
        end
    end

    assign rd_state = st_q[rd_blk];
    assign rd_vec   = vec_q[rd_blk];

    // R2
    em_single_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == DS_EM) |-> ($countones(wr_vec) == 1));

endmodule

// File: rtl/dir_busy.sv
module dir_busy #(
    parameter int NBLK = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_en,
    input  logic [$clog2(NBLK)-1:0] set_blk,
    input  logic                    clr_en,
    input  logic [$clog2(NBLK)-1:0] clr_blk,
    input  logic [$clog2(NBLK)-1:0] chk_blk,
    output logic                    chk_busy
);
    localparam int BW = $clog2(NBLK);

    logic [NBLK-1:0] busy_q;

    for (genvar g = 0; g < NBLK; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                busy_q[g] <= 1'b0;
            else if (set_en && set_blk == BW'(g))
                busy_q[g] <= 1'b1;
            else if (clr_en && clr_blk == BW'(g))
                busy_q[g] <= 1'b0;
        end
    end

    assign chk_busy = busy_q[chk_blk];

    // R9
    busy_set_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !busy_q[set_blk]);

endmodule

// File: rtl/dir_decide.sv
module dir_decide
    import dir_pkg::*;
#(
    parameter int NCACHE = 4
) (
    input  logic                          excl,
    input  logic [$clog2(NCACHE)-1:0]     src,
    input  dstate_e                       cur_state,
    input  logic [NCACHE-1:0]             cur_vec,
    output logic                          need_fwd,
    output logic                          fwd_int,
    output logic [NCACHE-1:0]             fwd_mask,
    output logic [$clog2(NCACHE+1)-1:0]   inv_cnt,
    output logic                          rsp_now,
    output rkind_e                        rsp_kind,
    output rkind_e                        grant_kind,
    output dstate_e                       new_state,
    output logic [NCACHE-1:0]             new_vec
);
    localparam int PW = $clog2(NCACHE + 1);

    logic [NCACHE-1:0] self_bit;
    logic [NCACHE-1:0] others;
    logic              has_copy;

    assign self_bit = NCACHE'(1) << src;
    assign others   = cur_vec & ~self_bit;
    assign has_copy = cur_vec[src];
    assign inv_cnt  = PW'($countones(others));

    always_comb begin
        need_fwd   = 1'b0;
        fwd_int    = 1'b0;
        fwd_mask   = '0;
        rsp_now    = 1'b0;
        rsp_kind   = RK_DATA;
        grant_kind = RK_DATA;
        new_state  = DS_EM;
        new_vec    = self_bit;
        if (excl) begin
            if (cur_state != DS_U && others != '0) begin
                need_fwd   = 1'b1;
                fwd_mask   = others;
                grant_kind = (cur_state == DS_EM || has_copy) ? RK_NODATA : RK_DATA;
            end else begin
                rsp_now  = 1'b1;
                rsp_kind = (cur_state != DS_U && has_copy) ? RK_NODATA : RK_DATA;
            end
        end else begin
            unique case (cur_state)
                DS_S: begin
                    rsp_now   = 1'b1;
                    new_state = DS_S;
                    new_vec   = cur_vec | self_bit;
                end
                DS_EM: begin
                    if (others != '0) begin
                        need_fwd  = 1'b1;
                        fwd_int   = 1'b1;
                        fwd_mask  = others;
                        new_state = DS_S;
                        new_vec   = cur_vec | self_bit;
                    end else begin
                        rsp_now = 1'b1;
                    end
                end
                default: begin
                    rsp_now = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int NBLK   = 8,
    parameter int OCC    = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_excl,
    input  logic [$clog2(NCACHE)-1:0] req_src,
    input  logic [$clog2(NBLK)-1:0]   req_blk,
    input  logic                      ack_valid,
    input  logic                      ack_fin,
    input  logic [$clog2(NCACHE)-1:0] ack_src,
    input  logic [$clog2(NBLK)-1:0]   ack_blk,
    output logic                      rsp_valid,
    output logic [1:0]                rsp_kind,
    output logic [$clog2(NCACHE)-1:0] rsp_dst,
    output logic [$clog2(NBLK)-1:0]   rsp_blk,
    output logic                      fwd_valid,
    output logic                      fwd_intv,
    output logic [NCACHE-1:0]         fwd_mask,
    output logic [$clog2(NCACHE)-1:0] fwd_req,
    output logic [$clog2(NBLK)-1:0]   fwd_blk
);
    localparam int IW = $clog2(NCACHE);
    localparam int BW = $clog2(NBLK);
    localparam int PW = $clog2(NCACHE + 1);
    localparam int OW = $clog2(OCC + 1);

    fsm_e            st_q, st_d;
    logic [OW-1:0]   occ_q;
    logic [OW-1:0]   lat_q;
    logic [PW-1:0]   pend_q;
    logic            cur_excl;
    logic [IW-1:0]   cur_src;
    logic [BW-1:0]   cur_blk;

    dstate_e           tb_state;
    logic [NCACHE-1:0] tb_vec;
    logic              busy_hit;

    logic              d_need_fwd, d_fwd_int, d_rsp_now;
    logic [NCACHE-1:0] d_fwd_mask, d_new_vec;
    logic [PW-1:0]     d_inv_cnt;
    rkind_e            d_rsp_kind, d_grant_kind;
    dstate_e           d_new_state;

    logic              need_inv, accept, inv_hit, upd_en;
    rkind_e            rk;

    dir_table #(.NCACHE(NCACHE), .NBLK(NBLK)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(cur_blk), .rd_state(tb_state), .rd_vec(tb_vec),
        .wr_en(upd_en), .wr_blk(cur_blk), .wr_state(d_new_state), .wr_vec(d_new_vec)
    );

    dir_busy #(.NBLK(NBLK)) u_busy (
        .clk(clk), .rst_n(rst_n),
        .set_en(upd_en), .set_blk(cur_blk),
        .clr_en(ack_valid && ack_fin), .clr_blk(ack_blk),
        .chk_blk(req_blk), .chk_busy(busy_hit)
    );

    dir_decide #(.NCACHE(NCACHE)) u_decide (
        .excl(cur_excl), .src(cur_src), .cur_state(tb_state), .cur_vec(tb_vec),
        .need_fwd(d_need_fwd), .fwd_int(d_fwd_int), .fwd_mask(d_fwd_mask),
        .inv_cnt(d_inv_cnt), .rsp_now(d_rsp_now), .rsp_kind(d_rsp_kind),
        .grant_kind(d_grant_kind), .new_state(d_new_state), .new_vec(d_new_vec)
    );

    assign need_inv = d_need_fwd && !d_fwd_int;
    assign accept   = (st_q == F_IDLE) && req_valid;
    assign inv_hit  = (st_q == F_WAIT_INV) && ack_valid && !ack_fin &&
                      (ack_blk == cur_blk) && d_fwd_mask[ack_src];
    assign upd_en   = ((st_q == F_ISSUE) && !need_inv) || (st_q == F_GRANT);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            F_IDLE:     if (req_valid) st_d = busy_hit ? F_REFUSE : F_LOOKUP;
            F_LOOKUP:   if (occ_q == '0) st_d = F_ISSUE;
            F_ISSUE:    st_d = need_inv ? F_WAIT_INV : F_IDLE;
            F_WAIT_INV: if (inv_hit && pend_q == PW'(1)) st_d = F_GRANT;
            F_GRANT:    st_d = F_IDLE;
            F_REFUSE:   st_d = F_IDLE;
            default:    st_d = F_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= F_IDLE;
            occ_q    <= '0;
            lat_q    <= '0;
            pend_q   <= '0;
            cur_excl <= 1'b0;
            cur_src  <= '0;
            cur_blk  <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                cur_excl <= req_excl;
                cur_src  <= req_src;
                cur_blk  <= req_blk;
                occ_q    <= OW'(OCC - 1);
                lat_q    <= '0;
            end
            if (st_q == F_LOOKUP) begin
                if (occ_q != '0) occ_q <= occ_q - OW'(1);
                lat_q <= lat_q + OW'(1);
            end
            if (st_q == F_ISSUE)
                pend_q <= d_inv_cnt;
            else if (inv_hit)
                pend_q <= pend_q - PW'(1);
        end
    end

    // outputs
    always_comb begin
        rsp_valid = 1'b0;
        rk        = RK_DATA;
        fwd_valid = 1'b0;
        fwd_intv  = 1'b0;
        fwd_mask  = '0;
        unique case (st_q)
            F_ISSUE: begin
                rsp_valid = d_rsp_now;
                rk        = d_rsp_kind;
                fwd_valid = d_need_fwd;
                fwd_intv  = d_fwd_int;
                fwd_mask  = d_fwd_mask;
            end
            F_GRANT: begin
                rsp_valid = 1'b1;
                rk        = d_grant_kind;
            end
            F_REFUSE: begin
                rsp_valid = 1'b1;
                rk        = RK_NACK;
            end
            default: ;
        endcase
    end

    assign req_ready = (st_q == F_IDLE);
    assign rsp_kind  = rk;
    assign rsp_dst   = cur_src;
    assign rsp_blk   = cur_blk;
    assign fwd_req   = cur_src;
    assign fwd_blk   = cur_blk;

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    occupancy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_ISSUE) |-> (lat_q == OW'(OCC)));

    // R5
    no_early_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0 && st_q == F_WAIT_INV) |-> !rsp_valid);

    // R9
    nack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd2) |-> $past(busy_hit));

    // R4
    int_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_intv) |-> ($countones(fwd_mask) == 1));

    // R5
    inv_skips_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_intv) |-> (!fwd_mask[fwd_req] && fwd_mask != '0));

endmodule

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;
    localparam int NC  = 4;
    localparam int NB  = 8;
    localparam int OCC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_excl = 1'b0;
    logic [1:0] req_src = '0;
    logic [2:0] req_blk = '0;
    logic       ack_valid = 1'b0, ack_fin = 1'b0;
    logic [1:0] ack_src = '0;
    logic [2:0] ack_blk = '0;
    logic       req_ready, rsp_valid, fwd_valid, fwd_intv;
    logic [1:0] rsp_kind, rsp_dst, fwd_req;
    logic [2:0] rsp_blk, fwd_blk;
    logic [3:0] fwd_mask;

    int n_chk = 0;
    int n_bad = 0;
    int g_n, g_rsp, g_kind, g_dst, g_fwd, g_intv, g_mask, g_req, g_blk;

    always #10 clk = ~clk;

    dir_home_ctrl #(.NCACHE(NC), .NBLK(NB), .OCC(OCC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_excl(req_excl),
        .req_src(req_src), .req_blk(req_blk),
        .ack_valid(ack_valid), .ack_fin(ack_fin), .ack_src(ack_src), .ack_blk(ack_blk),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst), .rsp_blk(rsp_blk),
        .fwd_valid(fwd_valid), .fwd_intv(fwd_intv), .fwd_mask(fwd_mask),
        .fwd_req(fwd_req), .fwd_blk(fwd_blk)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic issue(input logic x, input int src, input int blk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_excl  = x;
        req_src   = src[1:0];
        req_blk   = blk[2:0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_msg();
        g_n = 0;
        while (!(rsp_valid || fwd_valid) && g_n < 200) begin
            @(negedge clk);
            g_n++;
        end
        g_rsp = rsp_valid;  g_kind = rsp_kind; g_dst = rsp_dst;
        g_fwd = fwd_valid;  g_intv = fwd_intv; g_mask = fwd_mask;
        g_req = fwd_req;    g_blk = rsp_valid ? rsp_blk : fwd_blk;
        @(negedge clk);
    endtask

    task automatic ack(input logic fin, input int src, input int blk);
        ack_valid = 1'b1;
        ack_fin   = fin;
        ack_src   = src[1:0];
        ack_blk   = blk[2:0];
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 fwd_valid", fwd_valid, 0);
    endtask

    task automatic t_read_uncached();
        issue(1'b0, 0, 1);
        wait_msg();
        chk("R10 latency", g_n, OCC);
        chk("R2 rsp", g_rsp, 1);
        chk("R2 kind", g_kind, 0);
        chk("R2 dst", g_dst, 0);
        chk("R2 blk", g_blk, 1);
        chk("R2 no fwd", g_fwd, 0);
        chk("R10 ready again", req_ready, 1);
        ack(1'b1, 0, 1);
    endtask

    task automatic t_read_owned();
        issue(1'b0, 1, 1);
        wait_msg();
        chk("R4 fwd", g_fwd, 1);
        chk("R4 intv", g_intv, 1);
        chk("R4 mask", g_mask, 4'b0001);
        chk("R4 req id", g_req, 1);
        chk("R4 no rsp", g_rsp, 0);
        ack(1'b1, 1, 1);
    endtask

    task automatic t_read_shared();
        issue(1'b0, 2, 1);
        wait_msg();
        chk("R3 rsp", g_rsp, 1);
        chk("R3 kind", g_kind, 0);
        chk("R3 dst", g_dst, 2);
        chk("R3 no fwd", g_fwd, 0);
        ack(1'b1, 2, 1);
    endtask

    // sharers {0,1,2}; cache 1 is taken to have evicted silently
    task automatic t_readx_shared();
        issue(1'b1, 3, 1);
        wait_msg();
        chk("R5 fwd", g_fwd, 1);
        chk("R5 inv", g_intv, 0);
        chk("R5 mask", g_mask, 4'b0111);
        chk("R5 req id", g_req, 3);
        chk("R5 no rsp", g_rsp, 0);
        ack(1'b0, 0, 1);
        chk("R5 held after 1 ack", rsp_valid, 0);
        ack(1'b0, 1, 1);
        chk("R8 held after evicted ack", rsp_valid, 0);
        ack(1'b0, 2, 1);
        chk("R5 grant", rsp_valid, 1);
        chk("R6 grant kind data", rsp_kind, 0);
        chk("R6 grant dst", rsp_dst, 3);
        @(negedge clk);
        ack(1'b1, 3, 1);
    endtask

    task automatic t_after_inval();
        issue(1'b0, 0, 1);
        wait_msg();
        chk("R8 sole owner int", g_intv, 1);
        chk("R8 mask only 3", g_mask, 4'b1000);
        chk("R8 req id", g_req, 0);
        ack(1'b1, 0, 1);
    endtask

    // sharers {0,3}; requester 0 already holds a copy
    task automatic t_upgrade();
        issue(1'b1, 0, 1);
        wait_msg();
        chk("R5 upgrade mask", g_mask, 4'b1000);
        ack(1'b0, 3, 5);
        chk("R11 other block ack ignored", rsp_valid, 0);
        ack(1'b0, 2, 1);
        chk("R11 non-target ack ignored", rsp_valid, 0);
        ack(1'b0, 3, 1);
        chk("R6 upgrade rsp", rsp_valid, 1);
        chk("R6 upgrade nodata", rsp_kind, 1);
        chk("R6 upgrade dst", rsp_dst, 0);
        @(negedge clk);
        ack(1'b1, 0, 1);
    endtask

    task automatic t_sole_owner();
        issue(1'b1, 0, 1);
        wait_msg();
        chk("R10 sole latency", g_n, OCC);
        chk("R6 sole direct rsp", g_rsp, 1);
        chk("R6 sole nodata", g_kind, 1);
        chk("R6 sole no fwd", g_fwd, 0);
        ack(1'b1, 0, 1);
    endtask

    task automatic t_busy();
        issue(1'b0, 2, 2);
        wait_msg();
        chk("R2 blk2 data", g_kind, 0);
        issue(1'b0, 1, 2);
        wait_msg();
        chk("R9 nack latency", g_n, 0);
        chk("R9 nack kind", g_kind, 2);
        chk("R9 nack dst", g_dst, 1);
        chk("R9 nack no fwd", g_fwd, 0);
        ack(1'b1, 2, 2);
        issue(1'b0, 1, 2);
        wait_msg();
        chk("R9 served after fin", g_fwd, 1);
        chk("R9 entry unchanged mask", g_mask, 4'b0100);
        chk("R9 req id", g_req, 1);
        ack(1'b1, 1, 2);
    endtask

    task automatic t_readx_uncached();
        issue(1'b1, 1, 3);
        wait_msg();
        chk("R7 rsp", g_rsp, 1);
        chk("R7 data", g_kind, 0);
        chk("R7 dst", g_dst, 1);
        chk("R7 no fwd", g_fwd, 0);
        ack(1'b1, 1, 3);
        issue(1'b1, 2, 3);
        wait_msg();
        chk("R5 owner inv mask", g_mask, 4'b0010);
        chk("R5 owner inv kind", g_intv, 0);
        ack(1'b0, 1, 3);
        chk("R6 owner supplies nodata", rsp_kind, 1);
        chk("R6 owner grant", rsp_valid, 1);
        @(negedge clk);
        ack(1'b1, 2, 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_uncached();
        t_read_owned();
        t_read_shared();
        t_readx_shared();
        t_after_inval();
        t_upgrade();
        t_sole_owner();
        t_busy();
        t_readx_uncached();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule